// File: doc/BRIEF.md
# Round-Robin Wormhole Output Port

This block is one output side of a four-port mesh router. Each input channel whose head flit is routed to this output raises a request together with that head flit. The port picks one requester with a rotating-priority arbiter and locks onto it for a whole wormhole packet. It copies the locked input's flits, one at a time, into a single output holding register that drives the outgoing link. Each flit is 8-bit data plus start-of-packet and end-of-packet markers, and the port runs a valid/acknowledge handshake with the downstream router.

The port tells the locked input to pop its FIFO with a one-cycle read-ready pulse. The pulse comes in each cycle that a flit moves from that input into the holding register. After the tail flit is acknowledged, the lock is released and the priority pointer moves to the input just after the one that finished. A new arbitration takes place in the following cycle.

Top module: `wh_out_port`

## Requirements
- R1: While no packet is locked, the port grants the first requesting input found when counting upward, with wrap-around, from the priority pointer. When a packet's tail flit is acknowledged, the pointer becomes (owner + 1) mod 4.
- R2: Once an input is granted, only that input's flits appear on the link until its tail flit (the one with `flit_eop_i` set) has been accepted. After the tail is loaded, no read-ready pulse is issued until the lock is released.
- R3: While `link_valid_o` is high and `link_ack_i` is low, the link outputs hold their values on the next cycle. At most one flit is outstanding on the link.
- R4: Whenever `link_valid_o` is low, `link_data_o`, `link_sop_o` and `link_eop_o` are all zero.
- R5: Suppose the port is idle and a request is first sampled at rising edge k. Then the grant is taken at edge k, the first flit is loaded at edge k+1, and `link_valid_o` is high after edge k+1.
- R6: `rd_o` has at most one bit set, and only the owner's bit. That bit is high in exactly the cycles in which the owner's head flit is loaded, which requires the holding register to be empty or being acknowledged in that cycle. The number of pulses per input equals the number of flits that input delivers.
- R7: `link_ack_i` has no effect while `link_valid_o` is low.
- R8: After reset all outputs are zero and the priority pointer selects input 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per input: head flit is valid and routed to this output |
| flit_data_i | input | 32 | Head flit data of each input; input k uses bits [8k+7:8k] |
| flit_sop_i | input | 4 | Head flit start-of-packet marker per input |
| flit_eop_i | input | 4 | Head flit end-of-packet marker per input |
| rd_o | output | 4 | Read-ready pulse to the owning input's FIFO |
| link_valid_o | output | 1 | Outgoing flit valid |
| link_data_o | output | 8 | Outgoing flit data |
| link_sop_o | output | 1 | Outgoing start-of-packet |
| link_eop_o | output | 1 | Outgoing end-of-packet |
| link_ack_i | input | 1 | Downstream acceptance of the outgoing flit |

## Verification
The hardest situation to reach is a locked packet whose input runs dry in the middle of the packet while another input is already waiting. This is the only case in which a wrong release would let the waiting input's flit slip into the middle of the worm. The stimulus queues only the header of one packet and a single-flit packet on a second input. The rest of the first packet is supplied many cycles later, and the bench checks that the delivered stream stays contiguous per source and that the waiting input gets its turn only afterwards. The stimulus also drives all four inputs at once with an irregular acknowledge so that the rotation order is checked, and it holds acknowledge high during idle periods.

// File: rtl/wh_pkg.sv
package wh_pkg;
  parameter int unsigned DEF_PORTS  = 4;
  parameter int unsigned DEF_FLIT_W = 8;

  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned n);
    return (idx + 1) % n;
  endfunction
endpackage

// File: rtl/wh_rr_arbiter.sv
module wh_rr_arbiter #(
  parameter int unsigned NumIn = wh_pkg::DEF_PORTS,
  localparam int unsigned IdxW = (NumIn > 1) ? $clog2(NumIn) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NumIn-1:0] req_i,
  input  logic            release_i,
  input  logic [IdxW-1:0] release_idx_i,
  output logic            gnt_valid_o,
  output logic [IdxW-1:0] gnt_idx_o
);
  logic [IdxW-1:0] ptr_q;

  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int unsigned off = 0; off < NumIn; off++) begin
      int unsigned cand;
      cand = (int'(ptr_q) + off) % NumIn;
      if (!gnt_valid_o && req_i[cand]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IdxW'(cand);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (release_i) ptr_q <= IdxW'(wh_pkg::wrap_inc(int'(release_idx_i), NumIn));
  end
endmodule

// File: rtl/wh_flit_mux.sv
module wh_flit_mux #(
  parameter int unsigned NumIn = wh_pkg::DEF_PORTS,
  parameter int unsigned FlitW = wh_pkg::DEF_FLIT_W,
  localparam int unsigned IdxW = (NumIn > 1) ? $clog2(NumIn) : 1
) (
  input  logic [IdxW-1:0]        sel_i,
  input  logic [NumIn*FlitW-1:0] data_i,
  input  logic [NumIn-1:0]       sop_i,
  input  logic [NumIn-1:0]       eop_i,
  output logic [FlitW-1:0]       data_o,
  output logic                   sop_o,
  output logic                   eop_o
);
  logic [NumIn-1:0]       hit;
  logic [FlitW-1:0]       lane_d [NumIn];
  logic [NumIn-1:0]       lane_s, lane_e;

  for (genvar g = 0; g < NumIn; g++) begin : g_lane
    assign hit[g]    = (sel_i == IdxW'(g));
    assign lane_d[g] = data_i[g*FlitW +: FlitW] & {FlitW{hit[g]}};
    assign lane_s[g] = sop_i[g] & hit[g];
    assign lane_e[g] = eop_i[g] & hit[g];
  end

  always_comb begin
    data_o = '0;
    for (int unsigned k = 0; k < NumIn; k++) data_o = data_o | lane_d[k];
  end

  assign sop_o = |lane_s;
  assign eop_o = |lane_e;
endmodule

// File: rtl/wh_link_ctrl.sv
module wh_link_ctrl #(
  parameter int unsigned NumIn = wh_pkg::DEF_PORTS,
  parameter int unsigned FlitW = wh_pkg::DEF_FLIT_W,
  localparam int unsigned IdxW = (NumIn > 1) ? $clog2(NumIn) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NumIn-1:0] req_i,
  input  logic [FlitW-1:0] head_data_i,
  input  logic             head_sop_i,
  input  logic             head_eop_i,
  input  logic             gnt_valid_i,
  input  logic [IdxW-1:0]  gnt_idx_i,
  input  logic             ack_i,
  output logic [IdxW-1:0]  owner_o,
  output logic             release_o,
  output logic [NumIn-1:0] rd_o,
  output logic             valid_o,
  output logic [FlitW-1:0] data_o,
  output logic             sop_o,
  output logic             eop_o
);
  logic            locked_q, tail_q;
  logic [IdxW-1:0] owner_q;
  logic            valid_q, sop_q, eop_q;
  logic [FlitW-1:0] data_q;
  logic            accept, slot_free, load;

  assign accept    = valid_q & ack_i;
  assign slot_free = ~valid_q | ack_i;
  assign load      = locked_q & ~tail_q & req_i[owner_q] & slot_free;
  assign release_o = accept & eop_q;

  for (genvar g = 0; g < NumIn; g++) begin : g_rd
    assign rd_o[g] = load & (owner_q == IdxW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      tail_q   <= 1'b0;
      owner_q  <= '0;
    end else begin
      if (!locked_q && gnt_valid_i) begin
        locked_q <= 1'b1;
        owner_q  <= gnt_idx_i;
        tail_q   <= 1'b0;
      end
      if (load && head_eop_i) tail_q <= 1'b1;
      if (release_o) locked_q <= 1'b0;
    end
  end

  // single holding register: one flit outstanding, cleared when drained
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      sop_q   <= 1'b0;
      eop_q   <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= head_data_i;
      sop_q   <= head_sop_i;
      eop_q   <= head_eop_i;
    end else if (accept) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      sop_q   <= 1'b0;
      eop_q   <= 1'b0;
    end
  end

  assign owner_o = owner_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign sop_o   = sop_q;
  assign eop_o   = eop_q;
endmodule

// File: rtl/wh_out_port.sv
module wh_out_port #(
  parameter int unsigned NumIn = wh_pkg::DEF_PORTS,
  parameter int unsigned FlitW = wh_pkg::DEF_FLIT_W,
  localparam int unsigned IdxW = (NumIn > 1) ? $clog2(NumIn) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NumIn-1:0]       req_i,
  input  logic [NumIn*FlitW-1:0] flit_data_i,
  input  logic [NumIn-1:0]       flit_sop_i,
  input  logic [NumIn-1:0]       flit_eop_i,
  output logic [NumIn-1:0]       rd_o,
  output logic                   link_valid_o,
  output logic [FlitW-1:0]       link_data_o,
  output logic                   link_sop_o,
  output logic                   link_eop_o,
  input  logic                   link_ack_i
);
  logic            gnt_valid, release_w;
  logic [IdxW-1:0] gnt_idx, owner;
  logic [FlitW-1:0] head_data;
  logic            head_sop, head_eop;

  wh_rr_arbiter #(.NumIn(NumIn)) u_arb (
    .clk_i, .rst_ni,
    .req_i,
    .release_i     (release_w),
    .release_idx_i (owner),
    .gnt_valid_o   (gnt_valid),
    .gnt_idx_o     (gnt_idx)
  );

  wh_flit_mux #(.NumIn(NumIn), .FlitW(FlitW)) u_mux (
    .sel_i  (owner),
    .data_i (flit_data_i),
    .sop_i  (flit_sop_i),
    .eop_i  (flit_eop_i),
    .data_o (head_data),
    .sop_o  (head_sop),
    .eop_o  (head_eop)
  );

  wh_link_ctrl #(.NumIn(NumIn), .FlitW(FlitW)) u_ctrl (
    .clk_i, .rst_ni,
    .req_i,
    .head_data_i (head_data),
    .head_sop_i  (head_sop),
    .head_eop_i  (head_eop),
    .gnt_valid_i (gnt_valid),
    .gnt_idx_i   (gnt_idx),
    .ack_i       (link_ack_i),
    .owner_o     (owner),
    .release_o   (release_w),
    .rd_o,
    .valid_o     (link_valid_o),
    .data_o      (link_data_o),
    .sop_o       (link_sop_o),
    .eop_o       (link_eop_o)
  );
endmodule

// File: rtl/wh_out_port_chk.sv
module wh_out_port_chk #(
  parameter int unsigned NumIn = wh_pkg::DEF_PORTS,
  parameter int unsigned FlitW = wh_pkg::DEF_FLIT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NumIn-1:0] rd_o,
  input logic             link_valid_o,
  input logic [FlitW-1:0] link_data_o,
  input logic             link_sop_o,
  input logic             link_eop_o,
  input logic             link_ack_i
);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o && !link_ack_i |=> link_valid_o && $stable(link_data_o)
      && $stable(link_sop_o) && $stable(link_eop_o));

  p_idle_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_valid_o |-> (link_data_o == '0) && !link_sop_o && !link_eop_o);

  p_rd_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_o));

  p_rd_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_o) |-> (!link_valid_o || link_ack_i));

  p_tail_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o && link_eop_o |-> rd_o == '0);
endmodule

bind wh_out_port wh_out_port_chk #(.NumIn(NumIn), .FlitW(FlitW)) u_chk (
  .clk_i, .rst_ni, .rd_o, .link_valid_o, .link_data_o,
  .link_sop_o, .link_eop_o, .link_ack_i
);

// File: tb/wh_out_port_test.sv
module wh_out_port_test;
  localparam int N = 4;
  localparam int W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N*W-1:0] flit_data_i = '0;
  logic [N-1:0] flit_sop_i = '0, flit_eop_i = '0;
  logic [N-1:0] rd_o;
  logic link_valid_o, link_sop_o, link_eop_o;
  logic [W-1:0] link_data_o;
  logic link_ack_i = 1'b0;

  always #4 clk_i = ~clk_i;

  wh_out_port uut (.*);

  int vectors = 0, errors = 0;
  bit done = 0;

  // queued flit: {sop, eop, data}; data = {src[1:0], seq[5:0]}
  logic [9:0] q [N][$];
  int enq_cnt [N];
  int acc_cnt [N];
  int rd_cnt [N];
  int hdrs [$];
  int seq_no = 0;

  // reference state
  bit m_locked, m_tail, m_valid, m_sop, m_eop;
  int m_owner, m_ptr;
  logic [W-1:0] m_data;
  int cur_src;
  bit p_valid, p_ack, p_sop, p_eop;
  logic [W-1:0] p_data;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic add_pkt(input int src, input int len, input bit with_tail);
    for (int i = 0; i < len; i++) begin
      logic [9:0] f;
      f[9] = (i == 0);
      f[8] = with_tail && (i == len - 1);
      f[7:0] = {src[1:0], seq_no[5:0]};
      seq_no++;
      q[src].push_back(f);
      enq_cnt[src]++;
    end
  endtask

  task automatic add_rest(input int src, input int len);
    for (int i = 0; i < len; i++) begin
      logic [9:0] f;
      f[9] = 1'b0;
      f[8] = (i == len - 1);
      f[7:0] = {src[1:0], seq_no[5:0]};
      seq_no++;
      q[src].push_back(f);
      enq_cnt[src]++;
    end
  endtask

  task automatic drive_inputs();
    for (int k = 0; k < N; k++) begin
      req_i[k] = q[k].size() > 0;
      if (q[k].size() > 0) begin
        flit_sop_i[k] = q[k][0][9];
        flit_eop_i[k] = q[k][0][8];
        flit_data_i[k*W +: W] = q[k][0][7:0];
      end else begin
        flit_sop_i[k] = 1'b0;
        flit_eop_i[k] = 1'b0;
        flit_data_i[k*W +: W] = '0;
      end
    end
  endtask

  initial begin
    #(8 * 60000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      enq_cnt[k] = 0; acc_cnt[k] = 0; rd_cnt[k] = 0;
    end
    m_locked = 0; m_tail = 0; m_valid = 0; m_sop = 0; m_eop = 0;
    m_owner = 0; m_ptr = 0; m_data = '0; cur_src = -1;
    p_valid = 0; p_ack = 0; p_sop = 0; p_eop = 0; p_data = '0;

    repeat (3) @(negedge clk_i);
    // R8: reset values
    chk(link_valid_o == 0 && link_data_o == 0 && !link_sop_o && !link_eop_o && rd_o == 0,
        "R8 reset outputs", {link_valid_o, link_data_o}, 0);
    rst_ni = 1'b1;

    for (int cyc = 0; cyc < 2400; cyc++) begin
      bit ack, free, load, any;
      int win;
      logic [N-1:0] exp_rd;
      @(negedge clk_i);

      // registered outputs against reference (R3, R5)
      chk(link_valid_o == m_valid && link_data_o == m_data && link_sop_o == m_sop
          && link_eop_o == m_eop, "R3/R5 link outputs",
          {link_valid_o, link_sop_o, link_eop_o, link_data_o},
          {m_valid, m_sop, m_eop, m_data});
      if (!link_valid_o)
        chk(link_data_o == 0 && !link_sop_o && !link_eop_o, "R4 idle zero",
            {link_sop_o, link_eop_o, link_data_o}, 0);
      if (p_valid && !p_ack)
        chk(link_valid_o && link_data_o == p_data && link_sop_o == p_sop && link_eop_o == p_eop,
            "R3 hold", {link_valid_o, link_data_o}, {1'b1, p_data});
      if (p_ack && !p_valid && !m_valid)
        chk(!link_valid_o, "R7 idle ack", link_valid_o, 0);

      // stimulus schedule
      if (cyc == 2) begin add_pkt(0, 3, 1); add_pkt(2, 2, 1); end
      if (cyc == 40) begin
        add_pkt(0, 2, 1); add_pkt(1, 1, 1); add_pkt(2, 4, 1); add_pkt(3, 3, 1);
      end
      if (cyc == 120) add_pkt(1, 1, 0);
      if (cyc == 125) add_pkt(3, 1, 1);
      if (cyc == 140) add_rest(1, 2);
      if (cyc >= 200 && cyc < 2100 && ($urandom % 8) == 0) begin
        int s;
        s = $urandom % N;
        if (q[s].size() < 6) add_pkt(s, 1 + ($urandom % 5), 1);
      end
      if (cyc >= 40 && cyc < 120) ack = ($urandom % 2) == 0;
      else if (cyc >= 200 && cyc < 2100) ack = ($urandom % 10) < 7;
      else ack = 1'b1;

      link_ack_i = ack;
      drive_inputs();
      #1;

      // reference step
      free = !m_valid || ack;
      load = m_locked && !m_tail && req_i[m_owner] && free;
      exp_rd = load ? (N'(1) << m_owner) : '0;
      chk(rd_o == exp_rd, "R6 read-ready", rd_o, exp_rd);
      for (int k = 0; k < N; k++) if (rd_o[k]) rd_cnt[k]++;

      // delivered stream (R2)
      if (link_valid_o && ack) begin
        int src;
        src = int'(link_data_o[7:6]);
        acc_cnt[src]++;
        if (link_sop_o) begin
          chk(cur_src == -1, "R2 header inside worm", cur_src, -1);
          cur_src = src;
          hdrs.push_back(src);
        end else
          chk(src == cur_src, "R2 contiguity", src, cur_src);
        if (link_eop_o) cur_src = -1;
      end

      p_valid = link_valid_o; p_ack = ack; p_data = link_data_o;
      p_sop = link_sop_o; p_eop = link_eop_o;

      any = 0; win = 0;
      for (int off = 0; off < N; off++) begin
        int c;
        c = (m_ptr + off) % N;
        if (!any && req_i[c]) begin any = 1; win = c; end
      end
      if (load) begin
        logic [9:0] f;
        f = q[m_owner].pop_front();
        if (f[8]) m_tail = 1;
        m_valid = 1; m_sop = f[9]; m_eop = f[8]; m_data = f[7:0];
      end else if (m_valid && ack) begin
        if (m_eop) begin m_locked = 0; m_ptr = (m_owner + 1) % N; end
        m_valid = 0; m_sop = 0; m_eop = 0; m_data = '0;
      end
      if (!m_locked && any && !(p_valid && ack && p_eop)) begin
        m_locked = 1; m_owner = win; m_tail = 0;
      end
    end

    // R1 / R8 arbitration order
    begin
      int exp_h [8] = '{0, 2, 3, 0, 1, 2, 1, 3};
      chk(hdrs.size() >= 8, "R1 header count", hdrs.size(), 8);
      for (int i = 0; i < 8; i++)
        if (i < hdrs.size()) chk(hdrs[i] == exp_h[i], i < 2 ? "R8 first grant" : "R1 rotation",
                                 hdrs[i], exp_h[i]);
    end
    for (int k = 0; k < N; k++) begin
      chk(q[k].size() == 0, "R6 drained", q[k].size(), 0);
      chk(rd_cnt[k] == acc_cnt[k] && acc_cnt[k] == enq_cnt[k], "R6 pop count",
          rd_cnt[k], enq_cnt[k]);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule